// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block sits on a switch's internal 16-bit register bus and lets a host reach the registers of up to five embedded PHYs through a small window. The host first sets a direction latch, where 1 selects a read and 0 selects a write. It then writes to a trigger address. The trigger address itself names the PHY, the page and the register index, so the target never travels in a data word. In write mode, the data word of the trigger cycle goes to the PHY. In read mode, that data word is dropped, and the PHY's answer is later captured into a data register that the host reads.

The downstream side is a plain request/acknowledge port. The bridge raises a request in the cycle after an accepted trigger. It holds the command stable until the PHY acknowledges, and it shows a busy flag for that whole window. A trigger whose PHY selection is malformed is dropped and sets a sticky error flag.

Top module: `phy_bridge_top`

## Requirements
- R1: After a synchronous reset the bridge is idle: busy, request and error flag are low, the direction latch is in write mode, and the data register reads 0.
- R2: A host write to address 0x8028 loads bit 0 of the data word into the direction latch (1 = read, 0 = write) and ignores all other bits. A read of 0x8028 returns the latch in bit 0 and zeros elsewhere.
- R3: A host write to any other address with bit 15 set, except 0x8029, is a trigger. Bits 14:9 form a one-hot PHY select, where bit 9+n selects PHY n. Bits 7:5 give the page and bits 4:0 give the register index, and bit 8 is ignored. These fields appear on the downstream number, page and index outputs.
- R4: In write mode a trigger drives the downstream port with the write strobe high and the trigger's data word on the write-data output. The data register is left unchanged.
- R5: In read mode a trigger drives the write strobe low and the write-data output to 0. When the acknowledge arrives, the PHY's data is captured into the data register and can be read at 0x8029 from the next cycle on.
- R6: A trigger is dropped, with no request, when its select field has no bit set, more than one bit set, or a bit above PHY 4. Such a trigger sets the error flag, which stays set until reset.
- R7: Request and busy rise in the cycle after an accepted trigger. They stay high with number, page, index, strobe and write data unchanged until the cycle after acknowledge is sampled.
- R8: A well-formed trigger that arrives while busy is ignored: the outstanding command is kept, no second request follows, and the error flag is not set.
- R9: Reading 0x8029 returns the last completed read result. That value is not changed by write accesses, by a read still pending, or by host writes to 0x8029.
- R10: Reads of any address other than 0x8028 and 0x8029, including trigger addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Host bus cycle valid |
| bus_write | input | 1 | Host cycle is a write |
| bus_addr | input | 16 | Host register address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data (combinational on address) |
| phy_req | output | 1 | Downstream access request |
| phy_we | output | 1 | Downstream access is a write |
| phy_num | output | 3 | Target PHY number |
| phy_page | output | 3 | Target page |
| phy_regidx | output | 5 | Target register index |
| phy_wdata | output | 16 | Data for a downstream write |
| phy_ack | input | 1 | Downstream access complete |
| phy_rdata | input | 16 | Downstream read data, valid with acknowledge |
| busy | output | 1 | A downstream access is outstanding |
| sel_err | output | 1 | Sticky malformed-select flag |

## Verification
Directed triggers go to both extreme targets, PHY 0/page 0/register 0 and PHY 4/page 7/register 31. These show that the field extraction is correct at both ends and that the read and write directions send different strobe and data. Malformed selects follow: an empty select, two bits set, and the PHY-5 bit. Each must be dropped, which separates the one-hot check from a plain non-zero test. A second trigger sent during a long acknowledge delay shows that the outstanding command is protected. The random phase mixes direction, target, bit 8, data and acknowledge delay, with occasional bad selects, and checks the data register against a model that advances only on completed reads.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 16;
    localparam int TRIG_BIT  = 15;
    localparam int SEL_LSB   = 9;
    localparam int SEL_W     = TRIG_BIT - SEL_LSB;
    localparam int PAGE_LSB  = 5;
    localparam int PAGE_W    = 3;
    localparam int REG_LSB   = 0;
    localparam int REG_W     = 5;
    localparam int NUM_W     = $clog2(SEL_W);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028;
    localparam logic [ADDR_W-1:0] DATA_ADDR = 16'h8029;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_CTRL,
        HIT_DATA,
        HIT_TRIG
    } hit_e;

    typedef struct packed {
        logic [NUM_W-1:0]  num;
        logic [PAGE_W-1:0] page;
        logic [REG_W-1:0]  regidx;
    } phy_target_t;

    typedef struct packed {
        dir_e              dir;
        phy_target_t       tgt;
        logic [DATA_W-1:0] wdata;
    } phy_cmd_t;

    function automatic logic sel_is_valid(input logic [SEL_W-1:0] sel, input int nphy);
        int ones;
        logic high;
        ones = 0;
        high = 1'b0;
        for (int i = 0; i < SEL_W; i++) begin
            if (sel[i]) begin
                ones++;
                if (i >= nphy) high = 1'b1;
            end
        end
        return (ones == 1) && !high;
    endfunction

    function automatic logic [NUM_W-1:0] sel_to_num(input logic [SEL_W-1:0] sel);
        logic [NUM_W-1:0] n;
        n = '0;
        for (int i = 0; i < SEL_W; i++) begin
            if (sel[i]) n = NUM_W'(i);
        end
        return n;
    endfunction

endpackage

// File: rtl/phy_bus_decode.sv
module phy_bus_decode
    import phy_bridge_pkg::*;
#(
    parameter int NUM_PHY = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_e              hit,
    output phy_target_t       tgt,
    output logic              sel_ok
);

    logic [SEL_W-1:0] sel;

    assign sel = addr[SEL_LSB +: SEL_W];

    always_comb begin
        if (addr == CTRL_ADDR)      hit = HIT_CTRL;
        else if (addr == DATA_ADDR) hit = HIT_DATA;
        else if (addr[TRIG_BIT])    hit = HIT_TRIG;
        else                        hit = HIT_NONE;
    end

    always_comb begin
        tgt.num    = sel_to_num(sel);
        tgt.page   = addr[PAGE_LSB +: PAGE_W];
        tgt.regidx = addr[REG_LSB +: REG_W];
        sel_ok     = sel_is_valid(sel, NUM_PHY);
    end

endmodule

// File: rtl/phy_dir_reg.sv
module phy_dir_reg
    import phy_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wbit,
    output dir_e dir
);

    dir_e dir_q;

    always_ff @(posedge clk) begin
        if (rst)        dir_q <= DIR_WRITE;
        else if (wr_en) dir_q <= dir_e'(wbit);
    end

    assign dir = dir_q;

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (dir_q == dir_e'($past(wbit))));

endmodule

// File: rtl/phy_xfer_ctrl.sv
module phy_xfer_ctrl
    import phy_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              sel_ok,
    input  phy_target_t       tgt,
    input  dir_e              dir,
    input  logic [DATA_W-1:0] wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              pend,
    output phy_cmd_t          cmd,
    output logic [DATA_W-1:0] result,
    output logic              err
);

    logic     pend_q;
    phy_cmd_t cmd_q;
    logic [DATA_W-1:0] result_q;
    logic     err_q;
    logic     start;
    logic     bad;
    logic     done;

    assign start = trig && sel_ok && !pend_q;
    assign bad   = trig && !sel_ok;
    assign done  = pend_q && phy_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            cmd_q    <= '0;
            result_q <= '0;
        end else if (start) begin
            pend_q      <= 1'b1;
            cmd_q.dir   <= dir;
            cmd_q.tgt   <= tgt;
            cmd_q.wdata <= (dir == DIR_WRITE) ? wdata : '0;
        end else if (done) begin
            pend_q <= 1'b0;
            if (cmd_q.dir == DIR_READ) result_q <= phy_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      err_q <= 1'b0;
        else if (bad) err_q <= 1'b1;
    end

    assign pend   = pend_q;
    assign cmd    = cmd_q;
    assign result = result_q;
    assign err    = err_q;

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !phy_ack) |=> (pend_q && $stable(cmd_q)));

    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !pend_q);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R6
    bad_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && !sel_ok && !pend_q) |=> (!pend_q && err_q));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && cmd_q.dir == DIR_READ) |=> $stable(result_q));

    // R5
    read_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cmd_q.dir == DIR_READ) |=> (result_q == $past(phy_rdata)));

endmodule

// File: rtl/phy_bridge_top.sv
module phy_bridge_top
    import phy_bridge_pkg::*;
#(
    parameter int NUM_PHY = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [NUM_W-1:0]  phy_num,
    output logic [PAGE_W-1:0] phy_page,
    output logic [REG_W-1:0]  phy_regidx,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              busy,
    output logic              sel_err
);

    hit_e        hit;
    phy_target_t tgt;
    logic        sel_ok;
    dir_e        dir;
    logic        bus_wr;
    logic        pend;
    phy_cmd_t    cmd;
    logic [DATA_W-1:0] result;
    logic        err;

    assign bus_wr = bus_valid && bus_write;

    phy_bus_decode #(.NUM_PHY(NUM_PHY)) u_decode (
        .addr   (bus_addr),
        .hit    (hit),
        .tgt    (tgt),
        .sel_ok (sel_ok)
    );

    phy_dir_reg u_dir (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && hit == HIT_CTRL),
        .wbit  (bus_wdata[0]),
        .dir   (dir)
    );

    phy_xfer_ctrl u_xfer (
        .clk       (clk),
        .rst       (rst),
        .trig      (bus_wr && hit == HIT_TRIG),
        .sel_ok    (sel_ok),
        .tgt       (tgt),
        .dir       (dir),
        .wdata     (bus_wdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .pend      (pend),
        .cmd       (cmd),
        .result    (result),
        .err       (err)
    );

    always_comb begin
        case (hit)
            HIT_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, dir};
            HIT_DATA: bus_rdata = result;
            default:  bus_rdata = '0;
        endcase
    end

    assign phy_req    = pend;
    assign busy       = pend;
    assign phy_we     = (cmd.dir == DIR_WRITE);
    assign phy_num    = cmd.tgt.num;
    assign phy_page   = cmd.tgt.page;
    assign phy_regidx = cmd.tgt.regidx;
    assign phy_wdata  = cmd.wdata;
    assign sel_err    = err;

    // R5
    read_zero_wdata_chk: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_we) |-> (phy_wdata == '0));

    // R8
    busy_trig_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !phy_ack && bus_wr && hit == HIT_TRIG && sel_ok && !sel_err)
            |=> (!sel_err && $stable(phy_num) && $stable(phy_regidx)));

endmodule

// File: tb/tb_phy_bridge_top.sv
module tb_phy_bridge_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        phy_req;
    logic        phy_we;
    logic [2:0]  phy_num;
    logic [2:0]  phy_page;
    logic [4:0]  phy_regidx;
    logic [15:0] phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        busy;
    logic        sel_err;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    int next_delay = 2;
    int wcnt = 0;
    bit req_seen = 0;
    int tx = 0;

    logic [15:0] exp_data = '0;
    bit exp_err = 0;

    phy_bridge_top dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_num(phy_num),
        .phy_page(phy_page), .phy_regidx(phy_regidx), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata), .busy(busy), .sel_err(sel_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] phy_answer(input int n, input int p, input int r, input int t);
        return {1'b1, 4'(t), 3'(n), 3'(p), 5'(r)};
    endfunction

    function automatic logic [15:0] trig_addr(input logic [5:0] sel, input int p, input int r, input bit b8);
        return 16'h8000 | (16'(sel) << 9) | (16'(b8) << 8) | (16'(p) << 5) | 16'(r);
    endfunction

    // PHY responder: acknowledges each request after next_delay cycles
    always @(negedge clk) begin
        if (phy_ack) begin
            phy_ack = 1'b0;
        end else if (phy_req) begin
            if (!req_seen) begin
                req_seen = 1;
                wcnt = next_delay;
            end else if (wcnt == 0) begin
                tx++;
                phy_rdata = phy_answer(phy_num, phy_page, phy_regidx, tx);
                phy_ack = 1'b1;
                req_seen = 0;
            end else begin
                wcnt--;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        for (int i = 0; i < 80; i++) begin
            if (!busy) return;
            @(negedge clk);
        end
        check(req, 32'(busy), 32'd0);
    endtask

    task automatic check_req(input string req, input int n, input int p, input int r,
                             input bit we, input logic [15:0] wd);
        check({req, " req"},   32'(phy_req), 1);
        check({req, " busy"},  32'(busy), 1);
        check({req, " num"},   32'(phy_num), 32'(n));
        check({req, " page"},  32'(phy_page), 32'(p));
        check({req, " reg"},   32'(phy_regidx), 32'(r));
        check({req, " we"},    32'(phy_we), 32'(we));
        check({req, " wdata"}, 32'(phy_wdata), 32'(wd));
    endtask

    // one well-formed access; checks downstream fields and data register
    task automatic do_access(input bit rd, input int n, input int p, input int r,
                             input bit b8, input logic [15:0] d, input int dly);
        logic [15:0] v;
        int t0;
        next_delay = dly;
        bus_wr(16'h8028, {15'h0, rd});
        bus_wr(trig_addr(6'(1 << n), p, r, b8), d);
        check_req(rd ? "R5 R3 R7" : "R4 R3 R7", n, p, r, !rd, rd ? 16'h0 : d);
        bus_rd(16'h8029, v);
        check("R9 pending", 32'(v), 32'(exp_data));
        t0 = tx;
        wait_idle("R7 completion");
        check("R7 released", 32'(phy_req), 0);
        if (rd) exp_data = phy_answer(n, p, r, t0 + 1);
        bus_rd(16'h8029, v);
        check(rd ? "R5 result" : "R4 data kept", 32'(v), 32'(exp_data));
    endtask

    task automatic do_bad(input logic [5:0] sel, input int p, input int r);
        bus_wr(trig_addr(sel, p, r, 0), 16'hBEEF);
        exp_err = 1;
        check("R6 dropped", 32'(phy_req), 0);
        check("R6 err", 32'(sel_err), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 req", 32'(phy_req), 0);
        check("R1 err", 32'(sel_err), 0);
        bus_rd(16'h8028, v); check("R1 dir", 32'(v), 0);
        bus_rd(16'h8029, v); check("R1 data", 32'(v), 0);

        // R2 direction latch
        bus_wr(16'h8028, 16'h0001);
        bus_rd(16'h8028, v); check("R2 read mode", 32'(v), 1);
        bus_wr(16'h8028, 16'hFFFE);
        bus_rd(16'h8028, v); check("R2 only bit0", 32'(v), 0);

        // extremes of the target fields
        do_access(0, 0, 0, 0, 0, 16'h1234, 1);
        do_access(1, 4, 7, 31, 1, 16'hFFFF, 3);
        do_access(0, 4, 7, 31, 1, 16'hA5A5, 2);

        // R8 trigger while busy
        next_delay = 6;
        bus_wr(16'h8028, 16'h0001);
        bus_wr(trig_addr(6'b000100, 3, 9, 0), 16'h0);
        bus_wr(trig_addr(6'b000001, 5, 17, 0), 16'h0);
        check_req("R8 kept", 2, 3, 9, 0, 16'h0);
        check("R8 no err", 32'(sel_err), 0);
        wait_idle("R8 completion");
        exp_data = phy_answer(2, 3, 9, tx);
        @(negedge clk);
        check("R8 no second req", 32'(phy_req), 0);
        bus_rd(16'h8029, v); check("R8 first result", 32'(v), 32'(exp_data));

        // R9 host write to data register ignored
        bus_wr(16'h8029, 16'h0F0F);
        bus_rd(16'h8029, v); check("R9 write ignored", 32'(v), 32'(exp_data));

        // R10 other addresses read zero
        bus_rd(16'h1234, v); check("R10 plain", 32'(v), 0);
        bus_rd(16'h8200, v); check("R10 trigger addr", 32'(v), 0);

        // R6 malformed selects
        do_bad(6'b000000, 1, 1);
        do_bad(6'b000011, 2, 2);
        do_bad(6'b100000, 3, 3);
        bus_rd(16'h8029, v); check("R6 data kept", 32'(v), 32'(exp_data));

        // random mix
        for (int it = 0; it < 60; it++) begin
            if ($urandom_range(0, 7) == 0) begin
                logic [5:0] s;
                s = 6'($urandom_range(0, 63));
                if (s != 0 && (s & (s - 1)) == 0 && s < 6'd32) s = s | 6'b100000;
                do_bad(s, $urandom_range(0, 7), $urandom_range(0, 31));
            end else begin
                do_access(1'($urandom_range(0, 1)), $urandom_range(0, 4),
                          $urandom_range(0, 7), $urandom_range(0, 31),
                          1'($urandom_range(0, 1)), 16'($urandom),
                          $urandom_range(1, 5));
            end
            check("R6 sticky", 32'(sel_err), 32'(exp_err));
        end

        finish_run();
    end

endmodule